// File: doc/BRIEF.md
# Instruction Field Decoder with Upper-Immediate Prefix

This block takes one 32-bit instruction per valid strobe and splits it into its fields. Those fields are the operation code, the destination register, the two source registers and the immediate field. The instruction's format decides which fields carry meaning. A 64-entry format table, computed at elaboration from the operation code, classifies every code as register form, immediate form or reserved. All decoded outputs are registered and appear one clock after the instruction is presented.

The block also builds the full 32-bit immediate operand. A dedicated prefix instruction can supply the upper half of the operand for the instruction that comes after it. A two-state machine remembers whether such a prefix is waiting. In `PFX_IDLE` no upper half is held, and an immediate-form instruction gets its 16-bit field sign-extended. In `PFX_HELD` the latched upper half is placed above the 16-bit field, with no sign extension. The machine has four named transitions:
- *arm* (`PFX_IDLE` to `PFX_HELD`) happens on a prefix.
- *rearm* (`PFX_HELD` to `PFX_HELD`) happens on a further prefix, which replaces the held value.
- *consume* (`PFX_HELD` to `PFX_IDLE`) happens on any other valid instruction.
- *flush* (either state to `PFX_IDLE`) happens on reset or when the exception input is pulsed.

Top module: `insn_decode`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `dec_valid` is 0 and every decoded output is 0. No prefix is held after reset, so the first immediate-form instruction is sign-extended.
- R2: One clock after a valid instruction, `dec_opcode` equals bits 31:26, `dec_rd` equals bits 25:21 and `dec_ra` equals bits 20:16, whatever the format.
- R3: The format rule is applied in this order. An opcode with bit 5 clear and bits 2:0 all ones is reserved. Otherwise, an opcode with bit 3 set is immediate form (`dec_is_imm`=1). Every other opcode is register form. `dec_is_imm` and `dec_reserved` are never both 1.
- R4: In register form, `dec_rb` is bits 15:11, `dec_field` is bits 10:0 zero-extended to 16 bits, and `dec_imm` is 0.
- R5: In immediate form with no prefix held, `dec_rb` is 0, `dec_field` is bits 15:0, and `dec_imm` is bits 15:0 sign-extended to 32 bits.
- R6: Opcode 0x2C is the prefix. It latches its bits 15:0 as the upper half of the operand. The next immediate-form instruction then gets `dec_imm` = {latched value, own bits 15:0}, with no sign extension.
- R7: A held prefix is dropped by exactly one following valid instruction that is not a prefix, whatever its format, reserved included. Cycles without the valid strobe neither use nor drop it.
- R8: A prefix that follows a held prefix overwrites the latched value, and the prefix stays held.
- R9: A pulse on `exc_enter` drops a held prefix. This takes priority over a prefix presented in the same cycle. An instruction presented in that cycle is still decoded using the state held before the pulse.
- R10: For a reserved opcode, `dec_reserved` is 1 and `dec_rb`, `dec_field` and `dec_imm` are 0.
- R11: `dec_valid` is `insn_valid` delayed by one clock. While it is 0, the field outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction to decode |
| exc_enter | input | 1 | Exception entry pulse; drops a held prefix |
| dec_valid | output | 1 | Decoded outputs updated this cycle |
| dec_opcode | output | 6 | Operation code |
| dec_rd | output | 5 | Destination register index |
| dec_ra | output | 5 | First source register index |
| dec_rb | output | 5 | Second source register index (register form only) |
| dec_field | output | 16 | Raw immediate field for the instruction's format |
| dec_imm | output | 32 | Final 32-bit immediate operand |
| dec_is_imm | output | 1 | Instruction is immediate form |
| dec_reserved | output | 1 | Opcode is reserved |

## Verification
The hardest situation to reach is the collision of a held prefix with exception entry. An exception pulse can arrive in the same cycle as a second prefix, or in the same cycle as the instruction that would have used the held value. In each case the decode of that instruction and the state left behind point in different directions. The stimulus builds each collision explicitly: it arms a prefix, then drives the colliding instruction together with `exc_enter`, then follows with a negative-field immediate instruction. That last instruction shows through `dec_imm` whether the prefix survived. A sweep over all 64 opcodes, each issued both bare and behind a fresh prefix, covers every table entry in both prefix states.

// File: rtl/idec_pkg.sv
package idec_pkg;

    // Instruction format classes held in the opcode table.
    typedef enum logic [1:0] {
        FMT_REG = 2'd0,
        FMT_IMM = 2'd1,
        FMT_RSV = 2'd2
    } fmt_e;

    // Format rule, applied in priority order: reserved slots first,
    // then immediate form, register form for everything else.
    function automatic fmt_e fmt_of(input logic [31:0] code);
        if (!code[5] && (code[2:0] == 3'b111))
            return FMT_RSV;
        else if (code[3])
            return FMT_IMM;
        else
            return FMT_REG;
    endfunction

endpackage

// File: rtl/idec_fmt_table.sv
module idec_fmt_table #(
    parameter int unsigned OPC_W = 6
) (
    input  logic [OPC_W-1:0] opcode,
    output idec_pkg::fmt_e   fmt
);
    localparam int unsigned NUM_OPC = 1 << OPC_W;

    idec_pkg::fmt_e tbl [NUM_OPC];

    // One entry per opcode, filled at elaboration.
    for (genvar g = 0; g < NUM_OPC; g++) begin : g_entry
        assign tbl[g] = idec_pkg::fmt_of(32'(g));
    end

    assign fmt = tbl[opcode];

endmodule

// File: rtl/idec_prefix_fsm.sv
module idec_prefix_fsm #(
    parameter int unsigned IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             is_pfx,
    input  logic             exc,
    input  logic [IMM_W-1:0] pfx_val,
    output logic             pending,
    output logic [IMM_W-1:0] hi
);
    typedef enum logic {
        PFX_IDLE = 1'b0,
        PFX_HELD = 1'b1
    } pfx_state_e;

    pfx_state_e       state_q, state_d;
    logic [IMM_W-1:0] hi_q;

    // State register and held upper half.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PFX_IDLE;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (step && is_pfx && !exc)
                hi_q <= pfx_val;
        end
    end

    // Transitions: arm, rearm, consume, flush.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFX_IDLE: begin
                if (exc)                 state_d = PFX_IDLE;
                else if (step && is_pfx) state_d = PFX_HELD;
                else                     state_d = PFX_IDLE;
            end
            PFX_HELD: begin
                if (exc)       state_d = PFX_IDLE;
                else if (step) state_d = is_pfx ? PFX_HELD : PFX_IDLE;
                else           state_d = PFX_HELD;
            end
            default: state_d = PFX_IDLE;
        endcase
    end

    assign pending = (state_q == PFX_HELD);
    assign hi      = hi_q;

    assert_arm_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_pfx && !exc) |=> (pending && hi == $past(pfx_val)));

    assert_rearm_overwrites_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && step && is_pfx && !exc) |=> (pending && hi == $past(pfx_val)));

    assert_consume_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !is_pfx) |=> !pending);

    assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !exc) |=> ($stable(pending) && $stable(hi)));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc |=> !pending);

endmodule

// File: rtl/idec_field_split.sv
module idec_field_split #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned REG_W   = 5,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned SHORT_W = 11
) (
    input  logic [IMM_W-1:0]  low,
    input  idec_pkg::fmt_e    fmt,
    input  logic              pending,
    input  logic [IMM_W-1:0]  hi,
    output logic [REG_W-1:0]  rb,
    output logic [IMM_W-1:0]  field,
    output logic [WORD_W-1:0] imm
);
    localparam int unsigned EXT_W = WORD_W - IMM_W;

    logic [WORD_W-1:0] imm_sext;
    logic [WORD_W-1:0] imm_join;

    assign imm_sext = {{EXT_W{low[IMM_W-1]}}, low};
    assign imm_join = {hi, low};

    always_comb begin
        rb    = '0;
        field = '0;
        imm   = '0;
        unique case (fmt)
            idec_pkg::FMT_REG: begin
                rb    = low[SHORT_W +: REG_W];
                field = IMM_W'(low[SHORT_W-1:0]);
            end
            idec_pkg::FMT_IMM: begin
                field = low;
                imm   = pending ? imm_join : imm_sext;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/insn_decode.sv
module insn_decode #(
    parameter int unsigned         WORD_W  = 32,
    parameter int unsigned         OPC_W   = 6,
    parameter int unsigned         REG_W   = 5,
    parameter int unsigned         IMM_W   = 16,
    parameter int unsigned         SHORT_W = 11,
    parameter logic [OPC_W-1:0]    PFX_OPC = 6'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [WORD_W-1:0] insn_word,
    input  logic              exc_enter,
    output logic              dec_valid,
    output logic [OPC_W-1:0]  dec_opcode,
    output logic [REG_W-1:0]  dec_rd,
    output logic [REG_W-1:0]  dec_ra,
    output logic [REG_W-1:0]  dec_rb,
    output logic [IMM_W-1:0]  dec_field,
    output logic [WORD_W-1:0] dec_imm,
    output logic              dec_is_imm,
    output logic              dec_reserved
);
    localparam int unsigned OPC_LSB = WORD_W - OPC_W;
    localparam int unsigned RD_LSB  = OPC_LSB - REG_W;
    localparam int unsigned RA_LSB  = RD_LSB - REG_W;

    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  rd_c, ra_c, rb_c;
    logic [IMM_W-1:0]  field_c, hi;
    logic [WORD_W-1:0] imm_c;
    logic              is_pfx, pending;
    idec_pkg::fmt_e    fmt;

    assign opc    = insn_word[OPC_LSB +: OPC_W];
    assign rd_c   = insn_word[RD_LSB +: REG_W];
    assign ra_c   = insn_word[RA_LSB +: REG_W];
    assign is_pfx = (opc == PFX_OPC);

    idec_fmt_table #(.OPC_W(OPC_W)) u_table (
        .opcode (opc),
        .fmt    (fmt)
    );

    idec_prefix_fsm #(.IMM_W(IMM_W)) u_pfx (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (insn_valid),
        .is_pfx  (is_pfx),
        .exc     (exc_enter),
        .pfx_val (insn_word[IMM_W-1:0]),
        .pending (pending),
        .hi      (hi)
    );

    idec_field_split #(
        .WORD_W  (WORD_W),
        .REG_W   (REG_W),
        .IMM_W   (IMM_W),
        .SHORT_W (SHORT_W)
    ) u_split (
        .low     (insn_word[IMM_W-1:0]),
        .fmt     (fmt),
        .pending (pending),
        .hi      (hi),
        .rb      (rb_c),
        .field   (field_c),
        .imm     (imm_c)
    );

    // Output register stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            dec_opcode   <= '0;
            dec_rd       <= '0;
            dec_ra       <= '0;
            dec_rb       <= '0;
            dec_field    <= '0;
            dec_imm      <= '0;
            dec_is_imm   <= 1'b0;
            dec_reserved <= 1'b0;
        end else begin
            dec_valid <= insn_valid;
            if (insn_valid) begin
                dec_opcode   <= opc;
                dec_rd       <= rd_c;
                dec_ra       <= ra_c;
                dec_rb       <= rb_c;
                dec_field    <= field_c;
                dec_imm      <= imm_c;
                dec_is_imm   <= (fmt == idec_pkg::FMT_IMM);
                dec_reserved <= (fmt == idec_pkg::FMT_RSV);
            end
        end
    end

    assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> dec_valid);

    assert_hold_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> ($stable(dec_imm) && $stable(dec_opcode)));

    assert_fmt_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(dec_is_imm && dec_reserved));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_reserved) |-> (dec_imm == '0 && dec_rb == '0 && dec_field == '0));

    assert_reg_imm_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_is_imm && !dec_reserved) |-> (dec_imm == '0));

    assert_opcode_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> (dec_opcode == $past(insn_word[OPC_LSB +: OPC_W])));

endmodule

// File: tb/insn_decode_bench.sv
module insn_decode_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        insn_valid;
    logic [31:0] insn_word;
    logic        exc_enter;
    logic        dec_valid;
    logic [5:0]  dec_opcode;
    logic [4:0]  dec_rd, dec_ra, dec_rb;
    logic [15:0] dec_field;
    logic [31:0] dec_imm;
    logic        dec_is_imm, dec_reserved;

    always #10 clk = ~clk;

    insn_decode u_insn_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .insn_valid   (insn_valid),
        .insn_word    (insn_word),
        .exc_enter    (exc_enter),
        .dec_valid    (dec_valid),
        .dec_opcode   (dec_opcode),
        .dec_rd       (dec_rd),
        .dec_ra       (dec_ra),
        .dec_rb       (dec_rb),
        .dec_field    (dec_field),
        .dec_imm      (dec_imm),
        .dec_is_imm   (dec_is_imm),
        .dec_reserved (dec_reserved)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic        m_pend = 1'b0;
    logic [15:0] m_hi = 16'h0;

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd,
                                       input logic [4:0] ra, input logic [15:0] lo);
        return {op, rd, ra, lo};
    endfunction

    // Present one cycle of stimulus, check the registered result one clock later,
    // then advance the reference prefix model.
    task automatic issue(input logic [31:0] w, input bit v, input bit e);
        logic [5:0]  op;
        bit          res, isimm;
        logic [4:0]  e_rb;
        logic [15:0] e_field;
        logic [31:0] e_imm;
        string       t_fld, t_imm;
        op    = w[31:26];
        res   = !op[5] && (op[2:0] == 3'b111);
        isimm = !res && op[3];
        e_rb    = (!res && !isimm) ? w[15:11] : 5'd0;
        e_field = res ? 16'd0 : (isimm ? w[15:0] : {5'd0, w[10:0]});
        e_imm   = (res || !isimm) ? 32'd0 :
                  (m_pend ? {m_hi, w[15:0]} : {{16{w[15]}}, w[15:0]});
        t_fld = res ? "R10 field" : (isimm ? "R5 field" : "R4 field");
        t_imm = res ? "R10 imm" : (!isimm ? "R4 imm" : (m_pend ? "R6 imm" : "R5 imm"));
        @(negedge clk);
        insn_valid = v;
        insn_word  = w;
        exc_enter  = e;
        @(negedge clk);
        insn_valid = 1'b0;
        exc_enter  = 1'b0;
        if (v) begin
            cmp("R11 valid", {31'd0, dec_valid}, 32'd1);
            cmp("R2 opcode", {26'd0, dec_opcode}, {26'd0, op});
            cmp("R2 rd", {27'd0, dec_rd}, {27'd0, w[25:21]});
            cmp("R2 ra", {27'd0, dec_ra}, {27'd0, w[20:16]});
            cmp(t_fld, {16'd0, dec_field}, {16'd0, e_field});
            cmp(res ? "R10 rb" : "R4 rb", {27'd0, dec_rb}, {27'd0, e_rb});
            cmp(t_imm, dec_imm, e_imm);
            cmp("R3 is_imm", {31'd0, dec_is_imm}, {31'd0, isimm});
            cmp("R10 reserved", {31'd0, dec_reserved}, {31'd0, res});
        end else begin
            cmp("R11 idle", {31'd0, dec_valid}, 32'd0);
        end
        if (e)
            m_pend = 1'b0;
        else if (v && op == 6'h2C) begin
            m_pend = 1'b1;
            m_hi   = w[15:0];
        end else if (v)
            m_pend = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
    end

    initial begin
        rst_n      = 1'b0;
        insn_valid = 1'b0;
        insn_word  = 32'h0;
        exc_enter  = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R1 valid in reset", {31'd0, dec_valid}, 32'd0);
        cmp("R1 imm in reset", dec_imm, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 valid after reset", {31'd0, dec_valid}, 32'd0);
        cmp("R1 opcode after reset", {26'd0, dec_opcode}, 32'd0);

        // R1: first immediate instruction is sign-extended.
        issue(mk(6'h08, 5'd1, 5'd2, 16'h8000), 1'b1, 1'b0);
        cmp("R1 first imm", dec_imm, 32'hFFFF8000);

        // R6: prefix then immediate, no sign extension.
        issue(mk(6'h2C, 5'd0, 5'd0, 16'hABCD), 1'b1, 1'b0);
        issue(mk(6'h08, 5'd3, 5'd4, 16'h8001), 1'b1, 1'b0);
        cmp("R6 joined", dec_imm, 32'hABCD8001);

        // R8: second prefix overwrites the first.
        issue(mk(6'h2C, 5'd0, 5'd0, 16'h1111), 1'b1, 1'b0);
        issue(mk(6'h2C, 5'd0, 5'd0, 16'h2222), 1'b1, 1'b0);
        issue(mk(6'h0A, 5'd5, 5'd6, 16'h0034), 1'b1, 1'b0);
        cmp("R8 overwrite", dec_imm, 32'h22220034);

        // R7: idle cycles keep the prefix; a register-form instruction drops it.
        issue(mk(6'h2C, 5'd0, 5'd0, 16'h4321), 1'b1, 1'b0);
        issue(32'hFFFF_FFFF, 1'b0, 1'b0);
        issue(32'hFFFF_FFFF, 1'b0, 1'b0);
        issue(mk(6'h08, 5'd7, 5'd8, 16'h0010), 1'b1, 1'b0);
        cmp("R7 survives idle", dec_imm, 32'h43210010);
        issue(mk(6'h2C, 5'd0, 5'd0, 16'hABCD), 1'b1, 1'b0);
        issue(mk(6'h00, 5'd9, 5'd10, 16'hF7FF), 1'b1, 1'b0);
        issue(mk(6'h08, 5'd1, 5'd1, 16'h8001), 1'b1, 1'b0);
        cmp("R7 dropped by reg form", dec_imm, 32'hFFFF8001);
        issue(mk(6'h2C, 5'd0, 5'd0, 16'hABCD), 1'b1, 1'b0);
        issue(mk(6'h07, 5'd2, 5'd2, 16'hFFFF), 1'b1, 1'b0);
        issue(mk(6'h08, 5'd1, 5'd1, 16'h9000), 1'b1, 1'b0);
        cmp("R7 dropped by reserved", dec_imm, 32'hFFFF9000);

        // R9: exception pulse alone, with a prefix, and with a consumer.
        issue(mk(6'h2C, 5'd0, 5'd0, 16'h5555), 1'b1, 1'b0);
        issue(32'h0, 1'b0, 1'b1);
        issue(mk(6'h08, 5'd1, 5'd1, 16'h8002), 1'b1, 1'b0);
        cmp("R9 flush alone", dec_imm, 32'hFFFF8002);
        issue(mk(6'h2C, 5'd0, 5'd0, 16'h5555), 1'b1, 1'b0);
        issue(mk(6'h2C, 5'd0, 5'd0, 16'h7777), 1'b1, 1'b1);
        cmp("R9 colliding prefix uses old", dec_imm, 32'h55557777);
        issue(mk(6'h08, 5'd1, 5'd1, 16'h8003), 1'b1, 1'b0);
        cmp("R9 flush beats prefix", dec_imm, 32'hFFFF8003);
        issue(mk(6'h2C, 5'd0, 5'd0, 16'h1234), 1'b1, 1'b0);
        issue(mk(6'h08, 5'd1, 5'd1, 16'h0005), 1'b1, 1'b1);
        cmp("R9 consumer in flush cycle", dec_imm, 32'h12340005);
        issue(mk(6'h08, 5'd1, 5'd1, 16'h8000), 1'b1, 1'b0);
        cmp("R9 cleared after", dec_imm, 32'hFFFF8000);

        // R3: sweep every opcode, bare and behind a fresh prefix.
        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] lo;
                lo = 16'(k * 16'h6D2B + op * 16'h0107) ^ ((k == 1) ? 16'h8000 : 16'h0);
                issue(mk(6'(op), 5'(op), 5'(~op), lo), 1'b1, 1'b0);
                if (k < 2) begin
                    issue(mk(6'h2C, 5'd0, 5'd0, 16'(op * 16'h0421 + 1)), 1'b1, 1'b0);
                    issue(mk(6'(op), 5'(op + k), 5'(op ^ 3), lo), 1'b1, 1'b0);
                end
            end
        end

        summary();
    end

endmodule